// File: doc/BRIEF.md
# Three-Byte Serial Frame Sender

This block is a host-side transmitter that pushes one 24-bit word to a serial converter as three back-to-back 8-bit transfers. The word is made of zero padding, a two-bit mode field and a 16-bit code. The active-low select line goes low once before the first byte and stays low until the third byte is finished. Software-facing logic pulses `start_i` with a code and a mode. The block then runs the whole frame on its own, reports `busy_o` while it works, and pulses `done_o` when the frame ends.

The serial clock idles low. Data changes on each rising edge, so the receiver samples a settled bit on each falling edge. The internal byte shifter can be set to send either end first through a static input. When it is set to send the least significant bit first, each byte is bit-reversed before it is loaded, so the wire always carries the most significant bit first. The serial clock half-period and the minimum select-high time between frames are parameters counted in system clocks. At a 125 MHz system clock, the default half-period of 4 cycles gives about 15.6 MHz, which is below the 20 MHz limit of the lower supply range. The default gap keeps select high well over 33 ns.

Top module: `dac_frame_sender`

## Requirements
- R1: After reset, select is high, the serial clock is low, and busy and done are both low.
- R2: A frame carries 24 bits on the wire with the most significant bit first. Bits 23..18 are zero, bits 17..16 are the mode and bits 15..0 are the code, all captured at the accepted start.
- R3: Select stays low without a break for the whole frame, which has exactly 24 rising and 24 falling serial clock edges (three 8-bit transfers).
- R4: The serial clock is low whenever select is high. Serial data changes only together with a rising serial clock edge, so it is stable across every falling edge.
- R5: With `lsb_first_i` = 1 the shifter sends bit 0 of its byte first. Each byte is bit-reversed on load, so the wire content is identical to the `lsb_first_i` = 0 case.
- R6: Within a frame, each high phase of the serial clock lasts HALF_DIV system clocks, and consecutive rising edges are 2*HALF_DIV system clocks apart.
- R7: Between two frames, select stays high for at least GAP_CYC system clocks.
- R8: A start request while busy is high is ignored: it starts no frame and does not change the frame in progress.
- R9: done is a single-cycle pulse in the cycle select returns high. busy stays high from the accepted start through the end of the select-high gap.
- R10: The first rising serial clock edge comes at least HALF_DIV system clocks after select falls. Select rises at least HALF_DIV system clocks after the last falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to send one frame; taken only while idle |
| code_i | input | 16 | Data code placed in the low 16 frame bits |
| mode_i | input | 2 | Mode field placed in frame bits 17..16 |
| lsb_first_i | input | 1 | Static shifter order: 1 = shifter emits bit 0 first |
| sel_no | output | 1 | Frame select, active low |
| sclk_o | output | 1 | Serial clock, idle low |
| sdo_o | output | 1 | Serial data, changes on rising sclk |
| busy_o | output | 1 | Frame or select-high gap in progress |
| done_o | output | 1 | One-cycle pulse when select returns high |

## Verification
The assertions assume that `lsb_first_i` changes only while `busy_o` is low. They also assume that `code_i` and `mode_i` are valid in the cycle `start_i` is accepted. Under these assumptions the wire pattern depends only on the captured frame. The stimulus changes the shifter order only between frames, when the block is idle. It drives start pulses during busy only to check that they are ignored, and it holds the code and mode steady around each accepted start.

// File: rtl/dac_frame_pkg.sv
package dac_frame_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_GAP
  } tx_state_e;
endpackage

// File: rtl/half_tick.sv
module half_tick #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CNT_W = $clog2(DIV + 1);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CNT_W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R6
  tick_space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && DIV > 1) |=> !tick_o);
endmodule

// File: rtl/bit_mirror.sv
module bit_mirror #(
  parameter int W = 8
) (
  input  logic         rev_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] y_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y_o[i] = rev_i ? a_i[W-1-i] : a_i[i];
  end
endmodule

// File: rtl/byte_shifter.sv
module byte_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         lsb_first_i,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] d_i,
  output logic         head_o
);
  logic [W-1:0] q;

  assign head_o = lsb_first_i ? q[0] : q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (load_i)  q <= d_i;
    else if (shift_i) q <= lsb_first_i ? {1'b0, q[W-1:1]} : {q[W-2:0], 1'b0};
  end
endmodule

// File: rtl/dac_frame_sender.sv
module dac_frame_sender
  import dac_frame_pkg::*;
#(
  parameter int CODE_W   = 16,
  parameter int MODE_W   = 2,
  parameter int BYTE_W   = 8,
  parameter int N_BYTES  = 3,
  parameter int HALF_DIV = 4,
  parameter int GAP_CYC  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              lsb_first_i,
  output logic              sel_no,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int FRAME_W = BYTE_W * N_BYTES;
  localparam int PAD_W   = FRAME_W - CODE_W - MODE_W;
  localparam int IDX_W   = $clog2(N_BYTES);
  localparam int BIT_W   = $clog2(BYTE_W);
  localparam int GAP_W   = $clog2(GAP_CYC + 1);

  tx_state_e          state_q;
  logic [FRAME_W-1:0] frame_q, frame_d, frame_sh;
  logic [IDX_W-1:0]   byte_idx_q, idx_nxt;
  logic [BIT_W-1:0]   bit_cnt_q;
  logic [GAP_W-1:0]   gap_cnt_q;
  logic [BYTE_W-1:0]  load_byte, mir_byte;
  logic               tick, div_en, head, load_en, shift_en, last_bit, last_byte;

  assign frame_d   = {{PAD_W{1'b0}}, mode_i, code_i};
  assign idx_nxt   = byte_idx_q + 1'b1;
  assign frame_sh  = frame_q << (BYTE_W * int'(idx_nxt));
  assign load_byte = (state_q == ST_IDLE) ? frame_d[FRAME_W-1 -: BYTE_W]
                                          : frame_sh[FRAME_W-1 -: BYTE_W];
  assign last_bit  = (bit_cnt_q == BIT_W'(BYTE_W - 1));
  assign last_byte = (byte_idx_q == IDX_W'(N_BYTES - 1));
  assign div_en    = (state_q == ST_LEAD) || (state_q == ST_SHIFT) || (state_q == ST_TRAIL);

  assign load_en  = ((state_q == ST_IDLE) && start_i) ||
                    ((state_q == ST_SHIFT) && tick && sclk_o && last_bit && !last_byte);
  assign shift_en = (state_q == ST_SHIFT) && tick && sclk_o && !last_bit;

  half_tick #(.DIV(HALF_DIV)) u_tick (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(div_en), .tick_o(tick)
  );

  bit_mirror #(.W(BYTE_W)) u_mirror (
    .rev_i(lsb_first_i), .a_i(load_byte), .y_o(mir_byte)
  );

  byte_shifter #(.W(BYTE_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .lsb_first_i(lsb_first_i),
    .load_i(load_en), .shift_i(shift_en), .d_i(mir_byte), .head_o(head)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      frame_q    <= '0;
      byte_idx_q <= '0;
      bit_cnt_q  <= '0;
      gap_cnt_q  <= '0;
      sel_no     <= 1'b1;
      sclk_o     <= 1'b0;
      sdo_o      <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          frame_q    <= frame_d;
          byte_idx_q <= '0;
          bit_cnt_q  <= '0;
          sel_no     <= 1'b0;
          busy_o     <= 1'b1;
          state_q    <= ST_LEAD;
        end
        ST_LEAD: if (tick) begin
          sclk_o  <= 1'b1;
          sdo_o   <= head;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          if (sclk_o) begin
            sclk_o <= 1'b0;
            if (last_bit) begin
              bit_cnt_q <= '0;
              if (last_byte) state_q <= ST_TRAIL;
              else           byte_idx_q <= idx_nxt;
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end else begin
            sclk_o <= 1'b1;
            sdo_o  <= head;
          end
        end
        ST_TRAIL: if (tick) begin
          sel_no    <= 1'b1;
          done_o    <= 1'b1;
          gap_cnt_q <= '0;
          state_q   <= ST_GAP;
        end
        ST_GAP: begin
          if (gap_cnt_q == GAP_W'(GAP_CYC - 1)) begin
            busy_o  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            gap_cnt_q <= gap_cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // select-high length seen by the gap check
  logic [GAP_W-1:0] sel_hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        sel_hi_cnt <= GAP_W'(GAP_CYC);
    else if (!sel_no)                   sel_hi_cnt <= '0;
    else if (sel_hi_cnt != GAP_W'(GAP_CYC)) sel_hi_cnt <= sel_hi_cnt + 1'b1;
  end

  // R4
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_no |-> !sclk_o);
  // R4
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> $stable(sdo_o));
  // R9
  done_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($rose(sel_no) && busy_o));
  // R8
  start_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(frame_q));
  // R7
  sel_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sel_no) |-> (sel_hi_cnt == GAP_W'(GAP_CYC)));
endmodule

// File: tb/dac_frame_sender_tb_top.sv
module dac_frame_sender_tb_top;
  localparam int DIV = 4;
  localparam int GAP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] code = '0;
  logic [1:0] mode = '0;
  logic lsb_first = 1'b0;
  logic sel_n, sclk, sdo, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dac_frame_sender #(.HALF_DIV(DIV), .GAP_CYC(GAP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .code_i(code), .mode_i(mode),
    .lsb_first_i(lsb_first), .sel_no(sel_n), .sclk_o(sclk), .sdo_o(sdo),
    .busy_o(busy), .done_o(done)
  );

  // wire monitor, sampled on the falling system clock edge
  logic        p_sel = 1'b1, p_sclk = 1'b0, p_sdo = 1'b0, p_done = 1'b0;
  logic [23:0] cap = '0, last_frame = '0;
  int falls = 0, rises = 0, last_falls = 0, last_rises = 0;
  int since_rise = 0, high_cyc = 0, lead = 0, since_fall = 0, hi_cnt = 1000, last_gap = 1000;
  int frame_cnt = 0, done_cnt = 0;
  int half_bad = 0, hold_bad = 0, lead_bad = 0, idle_bad = 0, done_bad = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      since_rise++; since_fall++; lead++;
      if (sclk) high_cyc++;
      if (!sel_n) begin
        if (p_sel) begin
          falls = 0; rises = 0; lead = 0; cap = '0; last_gap = hi_cnt;
        end
        if (sclk && !p_sclk) begin
          if (rises == 0 && lead < DIV) lead_bad++;
          if (rises > 0 && since_rise != 2*DIV) half_bad++;
          rises++; since_rise = 0;
        end
        if (!sclk && p_sclk) begin
          if (high_cyc != DIV) half_bad++;
          if (sdo != p_sdo) hold_bad++;
          cap = {cap[22:0], sdo};
          falls++; since_fall = 0;
        end
      end else begin
        hi_cnt++;
        if (!p_sel) begin
          frame_cnt++; last_frame = cap; last_falls = falls; last_rises = rises;
          if (since_fall < DIV) lead_bad++;
          hi_cnt = 1;
        end
        if (sclk) idle_bad++;
      end
      if (!sclk) high_cyc = 0;
      if (done) begin
        done_cnt++;
        if (!(sel_n && !p_sel) || p_done) done_bad++;
      end
      p_sel = sel_n; p_sclk = sclk; p_sdo = sdo; p_done = done;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic wait_done();
    int n0 = done_cnt;
    do @(negedge clk); while (done_cnt == n0);
  endtask

  task automatic pulse_start(input logic [15:0] c, input logic [1:0] m);
    code = c; mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic check_frame(input logic [15:0] c, input logic [1:0] m, input string req);
    chk(last_frame == {6'b0, m, c}, req, 32'(last_frame), 32'({6'b0, m, c}));
    chk(last_falls == 24 && last_rises == 24, "R3 edge count", 32'(last_falls), 32'd24);
    chk(busy, "R9 busy through gap", 32'(busy), 32'd1);
    chk(half_bad == 0, "R6 clock phases", 32'(half_bad), 32'd0);
    chk(hold_bad == 0 && idle_bad == 0, "R4 data edge", 32'(hold_bad + idle_bad), 32'd0);
    chk(lead_bad == 0, "R10 select setup", 32'(lead_bad), 32'd0);
    chk(done_bad == 0, "R9 done pulse", 32'(done_bad), 32'd0);
  endtask

  task automatic t_reset();
    chk(sel_n && !sclk && !busy && !done, "R1 reset outputs",
        32'({sel_n, sclk, busy, done}), 32'b1000);
  endtask

  task automatic t_frame(input logic [15:0] c, input logic [1:0] m, input logic lsb);
    wait_idle();
    lsb_first = lsb;
    @(negedge clk);
    pulse_start(c, m);
    wait_done();
    check_frame(c, m, lsb ? "R5 mirrored frame" : "R2 frame content");
  endtask

  task automatic t_busy_ignore();
    int f0;
    wait_idle();
    lsb_first = 1'b0;
    f0 = frame_cnt;
    pulse_start(16'h5A3C, 2'b10);
    repeat (3) @(negedge clk);
    pulse_start(16'hFFFF, 2'b11);
    repeat (60) @(negedge clk);
    pulse_start(16'h0001, 2'b01);
    wait_done();
    check_frame(16'h5A3C, 2'b10, "R8 ignored start");
    @(negedge clk);
    pulse_start(16'h1111, 2'b01);   // during gap
    wait_idle();
    repeat (20) @(negedge clk);
    chk(frame_cnt == f0 + 1 && sel_n, "R8 no extra frame", 32'(frame_cnt - f0), 32'd1);
  endtask

  task automatic t_back_to_back();
    wait_idle();
    pulse_start(16'h0F0F, 2'b01);
    wait_done();
    while (busy) @(negedge clk);
    pulse_start(16'hF0F0, 2'b10);
    wait_done();
    check_frame(16'hF0F0, 2'b10, "R2 second frame");
    chk(last_gap >= GAP, "R7 select gap", 32'(last_gap), 32'(GAP));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_frame(16'hABCD, 2'b01, 1'b0);
    t_frame(16'h0000, 2'b00, 1'b0);
    t_frame(16'hFFFF, 2'b11, 1'b0);
    t_frame(16'hABCD, 2'b01, 1'b1);
    t_frame(16'h8001, 2'b10, 1'b1);
    t_frame(16'h1234, 2'b11, 1'b1);
    t_busy_ignore();
    t_back_to_back();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule